// File: doc/BRIEF.md
# Recursive Quadrature Sine/Cosine Oscillator

This block produces paired sine and cosine samples. It does not use a lookup table or a phase accumulator. It keeps a two-component vector (cos, sin) and, on every clock edge where the enable is high, rotates that vector by a fixed angle of 2π/SAMPLES_PER_CYCLE. The rotation is a 2x2 matrix built from four multiplies and two adds. The rotation coefficients are computed from the parameters at elaboration time. Frequency is not programmable at run time. The output frequency is the enable rate divided by SAMPLES_PER_CYCLE. For example, with the enable held high on a 50 MHz clock and 1000 samples per cycle, the output is 50 kHz. Slower tones come from pulsing the enable less often.

Samples are signed two's complement in Q1.(AMPL_BITS-1) format. Q1 format cannot represent +1 exactly, so full scale is the largest positive code, 2^(AMPL_BITS-1)-1. The vector is held internally with GUARD_BITS extra fraction bits, and the coefficients have matching precision. Each product is kept at full width, summed, rounded to nearest and saturated back to the state width. The outputs are the state rounded to AMPL_BITS bits.

Rounding error would otherwise change the amplitude slowly over time. To stop this, a step counter reloads the start vector (sin = 0, cos = full scale) each time a full cycle of SAMPLES_PER_CYCLE steps completes. A one-cycle valid strobe marks each new sample.

Top module: `quad_osc`

## Requirements
- R1: After k enabled steps since the last reload (0 < k < SAMPLES_PER_CYCLE), cos_o is within 2 LSB of round(M·cos(2πk/N)) and sin_o is within 2 LSB of round(M·sin(2πk/N)). Here M = 2^(AMPL_BITS-1)-1 and N = SAMPLES_PER_CYCLE.
- R2: Synchronous reset sets sin_o to 0, sets cos_o to M and clears valid_o. A reset asserted in the middle of a cycle restarts the sequence at step 0.
- R3: Outputs are signed two's complement with AMPL_BITS-1 fraction bits. The start value of cos_o is exactly M (0x7FFF for 16 bits), not an approximation of it.
- R4: On a clock edge where en is low, sin_o and cos_o keep their values.
- R5: The Nth enabled step after the previous reload restores exactly sin_o = 0 and cos_o = M. Step N-1 is a normal rotation and is not forced to the start values.
- R6: valid_o is high for exactly the cycle after each clock edge that samples en high, and low after an edge that samples en low.
- R7: Neither output ever takes the most negative code -2^(AMPL_BITS-1). Every intermediate result saturates to ±M.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Step enable: each edge where this is high advances the vector by one step |
| sin_o | output | AMPL_BITS | Sine sample, signed Q1 |
| cos_o | output | AMPL_BITS | Cosine sample, signed Q1 |
| valid_o | output | 1 | High for one cycle with each new sample |

## Verification
The bench checks both outputs after every step against real-valued sine and cosine of the step angle. It does this over several full cycles, with the enable held high and with the enable pulsed irregularly.

A wrong coefficient or a bad rounding step makes the error grow with each step, so the tolerance check catches it within a few steps. A step counter that is off by one moves the reload, and the exact start-value comparison at each cycle boundary reports it at the first boundary. Idle cycles are checked for an unchanged vector and a low strobe, so an enable leak shows up on the first idle edge.

// File: rtl/quad_osc.sv
module quad_osc #(
  parameter int AMPL_BITS         = 16,
  parameter int SAMPLES_PER_CYCLE = 64,
  parameter int GUARD_BITS        = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        en,
  output logic signed [AMPL_BITS-1:0] sin_o,
  output logic signed [AMPL_BITS-1:0] cos_o,
  output logic                        valid_o
);

  localparam int  SW = AMPL_BITS + GUARD_BITS;
  localparam int  CF = SW - 1;
  localparam int  CW = SW + 1;
  localparam int  PW = SW + CW;
  localparam int  IW = $clog2(SAMPLES_PER_CYCLE);
  localparam real PI    = 3.14159265358979323846;
  localparam real THETA = 2.0 * PI / real'(SAMPLES_PER_CYCLE);
  localparam real ONE   = 2.0 ** CF;
  localparam longint C_INT = longint'($cos(THETA) * ONE);
  localparam longint S_INT = longint'($sin(THETA) * ONE);
  localparam logic signed [CW-1:0] C_K = CW'(C_INT);
  localparam logic signed [CW-1:0] S_K = CW'(S_INT);
  localparam longint OMAX_INT  = (longint'(1) << (AMPL_BITS - 1)) - 1;
  localparam longint START_INT = OMAX_INT << GUARD_BITS;
  localparam logic signed [SW-1:0] START = SW'(START_INT);
  localparam logic signed [SW-1:0] SMAX  = {1'b0, {(SW-1){1'b1}}};
  localparam logic signed [SW-1:0] SMIN  = -SMAX;
  localparam logic signed [AMPL_BITS-1:0] OMAX = {1'b0, {(AMPL_BITS-1){1'b1}}};
  localparam logic signed [AMPL_BITS-1:0] OMIN = -OMAX;
  localparam logic [IW-1:0] LAST = IW'(SAMPLES_PER_CYCLE - 1);

  logic signed [SW-1:0] cos_q, sin_q;
  logic [IW-1:0]        idx_q;
  logic                 valid_q;

  function automatic logic signed [SW-1:0] rnd_sat(input logic signed [PW:0] a);
    logic signed [PW:0] r;
    r = (a + (PW+1)'(longint'(1) << (CF - 1))) >>> CF;
    if (r > (PW+1)'(SMAX))      return SMAX;
    else if (r < (PW+1)'(SMIN)) return SMIN;
    else                        return SW'(r);
  endfunction

  function automatic logic signed [AMPL_BITS-1:0] to_out(input logic signed [SW-1:0] v);
    logic signed [SW:0] r;
    r = ((SW+1)'(v) + (SW+1)'(longint'(1) << (GUARD_BITS - 1))) >>> GUARD_BITS;
    if (r > (SW+1)'(OMAX))      return OMAX;
    else if (r < (SW+1)'(OMIN)) return OMIN;
    else                        return AMPL_BITS'(r);
  endfunction

  logic signed [PW:0] cx, sx, kc, ks;
  logic signed [PW:0] cos_acc, sin_acc;
  logic signed [SW-1:0] cos_nx, sin_nx;

  assign cx = (PW+1)'(cos_q);
  assign sx = (PW+1)'(sin_q);
  assign kc = (PW+1)'(C_K);
  assign ks = (PW+1)'(S_K);
  assign cos_acc = cx * kc - sx * ks;
  assign sin_acc = sx * kc + cx * ks;
  assign cos_nx  = rnd_sat(cos_acc);
  assign sin_nx  = rnd_sat(sin_acc);

  always_ff @(posedge clk) begin
    if (rst) begin
      cos_q   <= START;
      sin_q   <= '0;
      idx_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= en;
      if (en) begin
        if (idx_q == LAST) begin
          cos_q <= START;
          sin_q <= '0;
          idx_q <= '0;
        end else begin
          cos_q <= cos_nx;
          sin_q <= sin_nx;
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign cos_o   = to_out(cos_q);
  assign sin_o   = to_out(sin_q);
  assign valid_o = valid_q;

  assert_start_after_reset_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (cos_o == OMAX && sin_o == '0 && !valid_o));

  assert_hold_when_idle_R4: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(cos_q) && $stable(sin_q) && $stable(idx_q)));

  assert_reload_at_boundary_R5: assert property (@(posedge clk) disable iff (rst)
    (en && idx_q == LAST) |=> (idx_q == '0 && cos_o == OMAX && sin_o == '0));

  assert_idx_range_R5: assert property (@(posedge clk) disable iff (rst)
    int'(idx_q) < SAMPLES_PER_CYCLE);

  assert_valid_new_sample_R6: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> !$stable(idx_q));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    (cos_o != -OMAX - 1'b1) && (sin_o != -OMAX - 1'b1));

endmodule

// File: tb/quad_osc_bench.sv
`timescale 1ns/1ps
module quad_osc_bench;
  localparam int  W = 16;
  localparam int  N = 64;
  localparam int  M = (1 << (W - 1)) - 1;
  localparam real PI = 3.14159265358979323846;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic signed [W-1:0] sin_o, cos_o;
  logic valid_o;

  int checks = 0;
  int fails  = 0;
  int k      = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  quad_osc #(.AMPL_BITS(W), .SAMPLES_PER_CYCLE(N), .GUARD_BITS(8)) u_quad_osc (
    .clk(clk), .rst(rst), .en(en), .sin_o(sin_o), .cos_o(cos_o), .valid_o(valid_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d (step %0d)", req, act, exp, k);
    end
  endtask

  task automatic step(input bit e);
    int pc, ps, ec, es;
    pc = cos_o; ps = sin_o;
    en = e;
    @(posedge clk);
    @(negedge clk);
    chk(valid_o == e, "R6 valid", int'(valid_o), int'(e));
    chk(cos_o != -M - 1 && sin_o != -M - 1, "R7 no min code", int'(cos_o), -M);
    if (!e) begin
      chk(cos_o == pc, "R4 cos hold", cos_o, pc);
      chk(sin_o == ps, "R4 sin hold", sin_o, ps);
    end else begin
      k = (k + 1) % N;
      if (k == 0) begin
        chk(cos_o == M, "R5 cos reload", cos_o, M);
        chk(sin_o == 0, "R5 sin reload", sin_o, 0);
      end else begin
        ec = int'(real'(M) * $cos(2.0 * PI * k / N));
        es = int'(real'(M) * $sin(2.0 * PI * k / N));
        chk(cos_o - ec <= 2 && ec - cos_o <= 2, "R1 cos", cos_o, ec);
        chk(sin_o - es <= 2 && es - sin_o <= 2, "R1 sin", sin_o, es);
      end
    end
  endtask

  task automatic check_start(input string tag);
    chk(cos_o == M, {tag, " R2/R3 cos start 0x7FFF"}, cos_o, M);
    chk(sin_o == 0, {tag, " R2 sin start"}, sin_o, 0);
    chk(valid_o == 1'b0, {tag, " R2 valid low"}, int'(valid_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_start("reset");
    k = 0;
    for (int i = 0; i < 3 * N + 10; i++) step(1'b1);
    for (int i = 0; i < 5; i++) step(1'b0);
    for (int i = 0; i < 3 * N; i++) step((i % 3) == 0 || (i % 7) == 5);
    rst = 1'b1; en = 1'b1;
    @(negedge clk);
    rst = 1'b0; en = 1'b0;
    check_start("mid reset");
    k = 0;
    for (int i = 0; i < N + 5; i++) step(1'b1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule